// File: doc/BRIEF.md
# Mailbox Transaction Sequencer

This block sits on the host side of a two-register command mailbox. It takes one register-access request and plays it out as a fixed series of mailbox commands. The request carries a kind, a target address and write data. The four kinds are CSR read, CSR write, MMIO read and MMIO write. For each mailbox command the engine writes the argument into the data register and then writes the opcode, with the run/busy flag set, into the command/status register. It then reads the command/status register until the far side clears busy.

Each command is allowed a limited number of status polls, and the engine waits a programmable number of idle cycles between polls. If an attempt times out, or if it completes with any status other than success, the engine reissues the whole command. After the last allowed attempt the engine records an error and moves on to the next step, so the sequence always reaches its closing command. Between the data step and the close step the engine reads the data register once. That value is returned as the result, with a one-cycle completion pulse and an error bit.

Top module: `mbx_seq`

## Requirements
- R1: A request is taken only when `req_ready` is high, which is the idle state. From the acceptance cycle until `done`, `req_ready` stays low, no other request is taken, and the bus is quiet whenever the block is idle.
- R2: Each command is issued in two bus writes. The first writes the argument to offset 0x4 (data register). The second writes `0x8000_0000 | opcode` to offset 0x0 (command/status register, bit 31 = run/busy).
- R3: Kind encoding is 0 = CSR read, 1 = CSR write, 2 = MMIO read, 3 = MMIO write, and the sequence ID is kind + 1. The steps run in this order: open (0x02, sequence ID); address step (0x13 + kind, address); data step (0x08 with the write data for write kinds, 0x07 with zero for read kinds); one bus read of offset 0x4; close (0x03, sequence ID).
- R4: After the command write the engine reads offset 0x0. When bit 31 reads as 1, the engine leaves the bus idle for `poll_gap` cycles before the next poll, or for 1 cycle when `poll_gap` is 0.
- R5: A poll with bit 31 clear ends the attempt. A low half of 0x0040 means success. Any other low half causes the command to be reissued, starting again from the data-register write. While bit 31 is set, the low bits are ignored.
- R6: An attempt whose POLL_LIMIT-th poll still reads busy has failed, and no further poll of that attempt is made.
- R7: A command that fails RETRY_LIMIT attempts in a row sets the error bit, and the sequence carries on with its next step.
- R8: `rdata` holds the value returned by the data-register read step of the finished transaction.
- R9: `done` is high for exactly one cycle per transaction. `error` is valid with `done` and holds its value until the next request is accepted. After reset both are 0.
- R10: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| poll_gap | input | GAP_W | Idle cycles between busy polls |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_kind | input | 2 | Access kind (see R3) |
| req_addr | input | 32 | Target address |
| req_wdata | input | 32 | Write data for write kinds |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Some command exhausted its attempts |
| rdata | output | 32 | Captured data-register value |
| bus_valid | output | 1 | Bus access request |
| bus_ready | input | 1 | Bus access accepted this cycle |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | BUS_AW | Mailbox register offset |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ready on reads |

## Verification
The hardest case to reach from the ports is retry exhaustion. One command has to fail on every allowed attempt while its neighbours succeed, both by timing out with busy held and by completing with a bad status, and the sequence must still close afterwards. The bench's mailbox model can pin a chosen step to permanent busy or to a permanent illegal status. It mixes these directed cases with random busy lengths, occasional bad statuses and random bus stalls. While a transaction is running, the bench also drives a stray request, which must have no effect on the opcodes and arguments the model sees.

// File: rtl/mbx_pkg.sv
// mbx_pkg: mailbox opcodes, status code and the step-to-opcode mapping
// shared by the sequencer and the command engine.
package mbx_pkg;
    localparam int          WORD_W    = 32;
    localparam int          BUSY_BIT  = 31;
    localparam logic [7:0]  OP_OPEN   = 8'h02;
    localparam logic [7:0]  OP_CLOSE  = 8'h03;
    localparam logic [7:0]  OP_RD_DAT = 8'h07;
    localparam logic [7:0]  OP_WR_DAT = 8'h08;
    localparam logic [7:0]  OP_ADDR0  = 8'h13;
    localparam logic [15:0] ST_OK     = 16'h0040;

    // Address-phase opcode: 0x13..0x16 follow the kind encoding.
    function automatic logic [7:0] addr_opcode(input logic [1:0] kind);
        return OP_ADDR0 + {6'b0, kind};
    endfunction

    // Data-phase opcode: odd kinds are writes.
    function automatic logic [7:0] data_opcode(input logic [1:0] kind);
        return kind[0] ? OP_WR_DAT : OP_RD_DAT;
    endfunction

    // Sequence ID carried by open and close.
    function automatic logic [WORD_W-1:0] seq_id(input logic [1:0] kind);
        return WORD_W'(kind) + WORD_W'(1);
    endfunction
endpackage

// File: rtl/mbx_cmd_engine.sv
// mbx_cmd_engine: issues one mailbox command (data write, command write,
// busy polling with an idle gap, whole-command retry), or a single read
// of the data register when rd_only is set.
// Assumes: start is only raised while idle; the bus holds one access open.
module mbx_cmd_engine
    import mbx_pkg::*;
#(
    parameter int POLL_LIMIT  = 100,
    parameter int RETRY_LIMIT = 10,
    parameter int GAP_W       = 16,
    parameter int BUS_AW      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_only,
    input  logic [7:0]        opcode,
    input  logic [WORD_W-1:0] arg,
    input  logic [GAP_W-1:0]  poll_gap,
    output logic              cmd_done,
    output logic              cmd_fail,
    output logic [WORD_W-1:0] rd_value,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic              bus_write,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    input  logic [WORD_W-1:0] bus_rdata
);
    localparam int PCW = $clog2(POLL_LIMIT + 1);
    localparam int RCW = $clog2(RETRY_LIMIT + 1);
    localparam logic [BUS_AW-1:0] CMD_OFS  = '0;
    localparam logic [BUS_AW-1:0] DATA_OFS = BUS_AW'(4);

    typedef enum logic [2:0] {E_IDLE, E_WDATA, E_WCMD, E_POLL, E_WAIT, E_RDREG} est_e;

    est_e              est;
    logic [7:0]        opc_q;
    logic [WORD_W-1:0] arg_q;
    logic [PCW-1:0]    polls;
    logic [RCW-1:0]    tries;
    logic [GAP_W-1:0]  wait_cnt;

    logic busy_seen, last_poll, attempt_bad, last_try;

    // Classify the poll response currently on the bus.
    always_comb begin
        busy_seen   = bus_rdata[BUSY_BIT];
        last_poll   = (polls == PCW'(POLL_LIMIT - 1));
        attempt_bad = busy_seen ? last_poll : (bus_rdata[15:0] != ST_OK);
        last_try    = (tries == RCW'(RETRY_LIMIT - 1));
    end

    // Command state machine with poll and retry counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            est      <= E_IDLE;
            opc_q    <= '0;
            arg_q    <= '0;
            polls    <= '0;
            tries    <= '0;
            wait_cnt <= '0;
            cmd_done <= 1'b0;
            cmd_fail <= 1'b0;
            rd_value <= '0;
        end else begin
            cmd_done <= 1'b0;
            case (est)
                E_IDLE: if (start) begin
                    opc_q    <= opcode;
                    arg_q    <= arg;
                    tries    <= '0;
                    cmd_fail <= 1'b0;
                    est      <= rd_only ? E_RDREG : E_WDATA;
                end
                E_WDATA: if (bus_ready) est <= E_WCMD;
                E_WCMD: if (bus_ready) begin
                    polls <= '0;
                    est   <= E_POLL;
                end
                E_POLL: if (bus_ready) begin
                    if (attempt_bad) begin
                        if (last_try) begin
                            cmd_done <= 1'b1;
                            cmd_fail <= 1'b1;
                            est      <= E_IDLE;
                        end else begin
                            tries <= tries + RCW'(1);
                            est   <= E_WDATA;
                        end
                    end else if (busy_seen) begin
                        polls    <= polls + PCW'(1);
                        wait_cnt <= (poll_gap == '0) ? GAP_W'(1) : poll_gap;
                        est      <= E_WAIT;
                    end else begin
                        cmd_done <= 1'b1;
                        est      <= E_IDLE;
                    end
                end
                E_WAIT: begin
                    if (wait_cnt <= GAP_W'(1)) est <= E_POLL;
                    else wait_cnt <= wait_cnt - GAP_W'(1);
                end
                E_RDREG: if (bus_ready) begin
                    rd_value <= bus_rdata;
                    cmd_done <= 1'b1;
                    est      <= E_IDLE;
                end
                default: est <= E_IDLE;
            endcase
        end
    end

    // Drive the bus request for the current state.
    always_comb begin
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_addr  = CMD_OFS;
        bus_wdata = '0;
        case (est)
            E_WDATA: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = DATA_OFS;
                bus_wdata = arg_q;
            end
            E_WCMD: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_wdata = {1'b1, 23'b0, opc_q};
            end
            E_POLL:  bus_valid = 1'b1;
            E_RDREG: begin
                bus_valid = 1'b1;
                bus_addr  = DATA_OFS;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mbx_seq_ctrl.sv
// mbx_seq_ctrl: walks one request through open, address, data,
// data-register read and close, and collects result and error.
// Assumes: the engine pulses eng_done once per started command.
module mbx_seq_ctrl
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [WORD_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              eng_start,
    output logic              eng_rd_only,
    output logic [7:0]        eng_opcode,
    output logic [WORD_W-1:0] eng_arg,
    input  logic              eng_done,
    input  logic              eng_fail,
    input  logic [WORD_W-1:0] eng_rd_value,
    output logic              done,
    output logic              error,
    output logic [WORD_W-1:0] rdata
);
    typedef enum logic [2:0] {S_IDLE, S_OPEN, S_ADDR, S_DATA, S_READ, S_CLOSE} st_e;

    st_e               st;
    logic [1:0]        kind_q;
    logic [WORD_W-1:0] addr_q, wdata_q;
    logic              launched;

    // Step sequencing, result capture and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            kind_q   <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            launched <= 1'b0;
            done     <= 1'b0;
            error    <= 1'b0;
            rdata    <= '0;
        end else begin
            done <= 1'b0;
            if (st == S_IDLE) begin
                if (req_valid) begin
                    kind_q   <= req_kind;
                    addr_q   <= req_addr;
                    wdata_q  <= req_wdata;
                    error    <= 1'b0;
                    launched <= 1'b0;
                    st       <= S_OPEN;
                end
            end else if (!launched) begin
                launched <= 1'b1;
            end else if (eng_done) begin
                launched <= 1'b0;
                error    <= error | eng_fail;
                if (st == S_READ) rdata <= eng_rd_value;
                if (st == S_CLOSE) begin
                    done <= 1'b1;
                    st   <= S_IDLE;
                end else begin
                    st <= st_e'(st + 3'd1);
                end
            end
        end
    end

    // Select opcode and argument for the current step.
    always_comb begin
        req_ready   = (st == S_IDLE);
        eng_start   = (st != S_IDLE) && !launched;
        eng_rd_only = 1'b0;
        eng_opcode  = OP_OPEN;
        eng_arg     = seq_id(kind_q);
        case (st)
            S_ADDR: begin
                eng_opcode = addr_opcode(kind_q);
                eng_arg    = addr_q;
            end
            S_DATA: begin
                eng_opcode = data_opcode(kind_q);
                eng_arg    = kind_q[0] ? wdata_q : '0;
            end
            S_READ:  eng_rd_only = 1'b1;
            S_CLOSE: eng_opcode  = OP_CLOSE;
            default: ;
        endcase
    end
endmodule

// File: rtl/mbx_seq.sv
// mbx_seq: top of the mailbox transaction sequencer; joins the step
// controller to the command engine that owns the mailbox bus.
// Assumes: a single-outstanding valid/ready bus toward the mailbox.
module mbx_seq
    import mbx_pkg::*;
#(
    parameter int POLL_LIMIT  = 100,
    parameter int RETRY_LIMIT = 10,
    parameter int GAP_W       = 16,
    parameter int BUS_AW      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GAP_W-1:0]  poll_gap,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [31:0]       req_addr,
    input  logic [31:0]       req_wdata,
    output logic              done,
    output logic              error,
    output logic [31:0]       rdata,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic              bus_write,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata
);
    logic              eng_start, eng_rd_only, eng_done, eng_fail;
    logic [7:0]        eng_opcode;
    logic [WORD_W-1:0] eng_arg, eng_rd_value;

    mbx_seq_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_kind     (req_kind),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .eng_start    (eng_start),
        .eng_rd_only  (eng_rd_only),
        .eng_opcode   (eng_opcode),
        .eng_arg      (eng_arg),
        .eng_done     (eng_done),
        .eng_fail     (eng_fail),
        .eng_rd_value (eng_rd_value),
        .done         (done),
        .error        (error),
        .rdata        (rdata)
    );

    mbx_cmd_engine #(
        .POLL_LIMIT  (POLL_LIMIT),
        .RETRY_LIMIT (RETRY_LIMIT),
        .GAP_W       (GAP_W),
        .BUS_AW      (BUS_AW)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (eng_start),
        .rd_only   (eng_rd_only),
        .opcode    (eng_opcode),
        .arg       (eng_arg),
        .poll_gap  (poll_gap),
        .cmd_done  (eng_done),
        .cmd_fail  (eng_fail),
        .rd_value  (eng_rd_value),
        .bus_valid (bus_valid),
        .bus_ready (bus_ready),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );
endmodule

// File: rtl/mbx_seq_checks.sv
// mbx_seq_checks: protocol properties of mbx_seq, bound to every instance.
module mbx_seq_checks #(
    parameter int BUS_AW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              done,
    input logic              bus_valid,
    input logic              bus_ready,
    input logic              bus_write,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [31:0]       bus_wdata
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !bus_valid);
    a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);
    a_r2_cmd_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_write && bus_addr == '0 |-> bus_wdata[31]);
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);
    a_r10_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_write)
                                    && $stable(bus_addr) && $stable(bus_wdata));
endmodule

bind mbx_seq mbx_seq_checks #(.BUS_AW(BUS_AW)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/sim_mbx_seq.sv
// sim_mbx_seq: mailbox target model plus directed and random requests.
module sim_mbx_seq;
    localparam int PL = 6;
    localparam int RL = 3;
    localparam int AW = 4;
    localparam int GW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [GW-1:0] poll_gap = GW'(10);
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_kind = '0;
    logic [31:0]   req_addr = '0, req_wdata = '0;
    logic          done, error;
    logic [31:0]   rdata;
    logic          bus_valid, bus_write;
    logic          bus_ready = 1'b0;
    logic [AW-1:0] bus_addr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata = '0;

    always #4 clk = ~clk;

    mbx_seq #(.POLL_LIMIT(PL), .RETRY_LIMIT(RL), .GAP_W(GW), .BUS_AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .poll_gap(poll_gap),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .error(error), .rdata(rdata),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected mailbox model state for the running transaction.
    logic [1:0]  cur_kind;
    logic [31:0] cur_addr, cur_wdata, data_reg = '0, rd_val = '0;
    int step = 0, run = 0, rd_seen = 0, busy_left = 0, polls_att = 0;
    int force_step = -1, force_kind = 0, gap_cnt = 0;
    bit err_exp = 0, live = 0, gap_track = 0;
    logic [15:0] status = 16'h0040;

    function automatic logic [7:0] exp_op(input int s, input logic [1:0] k);
        case (s)
            0: return 8'h02;
            1: return 8'h13 + {6'b0, k};
            2: return k[0] ? 8'h08 : 8'h07;
            default: return 8'h03;
        endcase
    endfunction

    function automatic logic [31:0] exp_arg(input int s, input logic [1:0] k,
                                            input logic [31:0] a, input logic [31:0] w);
        case (s)
            1: return a;
            2: return k[0] ? w : 32'h0;
            default: return 32'(k) + 32'd1;
        endcase
    endfunction

    task automatic attempt_end(input bit ok);
        live = 0;
        if (ok) begin
            step++;
            run = 0;
        end else begin
            run++;
            if (run == RL) begin
                err_exp = 1;
                step++;
                run = 0;
            end
        end
    endtask

    // Mailbox target: random stalls, busy windows and status codes.
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ready = 1'b0;
        end else begin
            if (gap_track && !bus_valid) gap_cnt++;
            if (bus_valid && ($urandom % 4 != 0)) begin
                bus_ready = 1'b1;
                if (bus_write && bus_addr == AW'(4)) begin
                    data_reg = bus_wdata;
                end else if (bus_write) begin
                    chk(bus_wdata == {24'h800000, exp_op(step, cur_kind)},
                        "R3 opcode", bus_wdata, {24'h800000, exp_op(step, cur_kind)});
                    chk(data_reg == exp_arg(step, cur_kind, cur_addr, cur_wdata),
                        "R2 argument", data_reg, exp_arg(step, cur_kind, cur_addr, cur_wdata));
                    live = 1;
                    polls_att = 0;
                    busy_left = (force_step == step && force_kind == 1) ? 1000 : int'($urandom % 3);
                    if (force_step == step && force_kind == 2) status = 16'h0090;
                    else status = ($urandom % 8 == 0) ? 16'h0082 : 16'h0040;
                end else if (bus_addr == '0) begin
                    chk(live, "R6 poll after attempt ended", 32'(polls_att), 32'(PL));
                    if (gap_track) begin
                        chk(gap_cnt == ((poll_gap == 0) ? 1 : int'(poll_gap)), "R4 poll gap",
                            32'(gap_cnt), (poll_gap == 0) ? 32'd1 : 32'(poll_gap));
                        gap_track = 0;
                    end
                    polls_att++;
                    if (busy_left > 0) begin
                        busy_left--;
                        bus_rdata = 32'h8000_0040;
                        if (polls_att == PL) attempt_end(0);
                        else begin
                            gap_track = 1;
                            gap_cnt = 0;
                        end
                    end else begin
                        bus_rdata = {1'b0, 15'($urandom), status};
                        attempt_end(status == 16'h0040);
                    end
                end else begin
                    chk(step == 3, "R3 data read order", 32'(step), 32'd3);
                    rd_val = $urandom;
                    bus_rdata = rd_val;
                    rd_seen++;
                end
            end else begin
                bus_ready = 1'b0;
            end
        end
    end

    task automatic run_txn(input logic [1:0] k, input logic [31:0] a, input logic [31:0] w,
                           input int fs, input int fk, input bit stray);
        step = 0; run = 0; err_exp = 0; rd_seen = 0; live = 0; gap_track = 0;
        force_step = fs; force_kind = fk;
        cur_kind = k; cur_addr = a; cur_wdata = w;
        @(negedge clk);
        chk(req_ready, "R1 ready when idle", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = w;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R1 busy after accept", 32'(req_ready), 32'd0);
        if (stray) begin
            req_valid = 1'b1; req_kind = ~k; req_addr = ~a; req_wdata = ~w;
            repeat (2) @(negedge clk);
            req_valid = 1'b0;
        end
        for (int i = 0; i < 20000; i++) begin
            if (done) break;
            @(negedge clk);
        end
        if (!done) begin
            chk(0, "R9 done never seen", 32'(done), 32'd1);
            return;
        end
        chk(rdata == rd_val, "R8 read data", rdata, rd_val);
        chk(error == err_exp, "R7 error flag", 32'(error), 32'(err_exp));
        chk(step == 4 && rd_seen == 1, "R3 all steps", 32'(step * 16 + rd_seen), 32'h41);
        @(negedge clk);
        chk(!done, "R9 done one cycle", 32'(done), 32'd0);
        chk(error == err_exp, "R9 error held", 32'(error), 32'(err_exp));
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!bus_valid && req_ready, "R1 quiet after done", 32'(bus_valid), 32'd0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !done && !error && !bus_valid && rdata == 0, "R9 reset state",
            {req_ready, done, error, bus_valid}, 4'b1000);
        for (int k = 0; k < 4; k++)
            run_txn(2'(k), 32'h1000_0000 + 32'(k), 32'hA5A5_0000 + 32'(k), -1, 0, 0);
        poll_gap = 0;
        run_txn(2'd2, 32'h0000_BEEF, 32'h0, -1, 0, 1);               // R1 stray request
        poll_gap = 5;
        run_txn(2'd0, 32'h0000_0044, 32'h0, 1, 1, 0);                // R6 R7 timeout
        run_txn(2'd3, 32'h0000_0088, 32'hDEAD_BEEF, 2, 2, 0);        // R5 R7 bad status
        run_txn(2'd1, 32'h0000_0010, 32'h1234_5678, 0, 2, 0);        // R7 open fails
        run_txn(2'd1, 32'h0000_0014, 32'h0, -1, 0, 0);               // R9 error cleared
        for (int n = 0; n < 30; n++) begin
            poll_gap = GW'($urandom % 7);
            run_txn(2'($urandom), $urandom, $urandom, -1, 0, ($urandom % 5 == 0));
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule